// File: doc/BRIEF.md
# Pipelined Vector Magnitude Unit

This block returns the Euclidean length of a two-component signed vector, `floor(sqrt(x*x + y*y))`, using logic only. Each component is a 9-bit two's-complement integer, and the result is a 10-bit unsigned integer. The block first squares both components and adds the squares. The sum is then passed to an integer square root that works on the radicand two bits at a time. For each result bit, the root subtracts a trial value from the partial remainder. If the remainder stays non-negative, the bit is one. The root needs no table and no storage other than its pipeline registers.

An elaboration parameter chooses between two forms of the root. In the staged form there is one register stage per result bit, and a new vector can enter on every enabled cycle. In the flat form all root steps are combinational, with a single output register behind them. A clock enable freezes every register in either form. An active-low asynchronous clear empties the whole datapath. The clear is released through a two-flop synchronizer.

Top module: `vec_mag`

## Requirements
- R1: With vector inputs `x` and `y` taken as 9-bit two's-complement values, `mag` carries the largest unsigned integer `r` such that `r*r <= x*x + y*y`.
- R2: The sum of squares is formed exactly over the whole input range, with no wrap-around. (-256,-256) gives 362, (255,-256) gives 361 and (255,255) gives 360.
- R3: Each root bit comes from a trial subtraction, and the result is exact at perfect squares and just below them. (5,12) gives 13, (6,8) gives 10, (1,1) gives 1 and (2,1) gives 2.
- R4: With `STAGED` = 1, the result for a vector sampled on enabled edge n appears on `mag` just after enabled edge n+10, which is 11 enabled edges in all. A new vector is taken on every enabled edge. Before the pipeline fills after a clear, `mag` reads 0.
- R5: While `ce` is 0, no register changes. `mag` keeps its value, and no vector in flight is lost or duplicated when `ce` returns to 1.
- R6: Driving `arst_n` to 0 sets `mag` to 0 at once, without waiting for a clock edge. Once the clear is released, results resume with the same latency.
- R7: Zero and single-axis vectors give the absolute value of the nonzero component. (0,0) gives 0, (-256,0) gives 256, (0,-256) gives 256 and (0,-1) gives 1.
- R8: With `STAGED` = 0, the result for a vector sampled on enabled edge n appears just after enabled edge n+1. The values are the same as in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| arst_n | input | 1 | Active-low asynchronous clear, released synchronously inside the block |
| ce | input | 1 | Clock enable; 0 holds all state |
| vec_x | input | 9 | First vector component, two's complement |
| vec_y | input | 9 | Second vector component, two's complement |
| mag | output | 10 | Floor of the vector's Euclidean length |

## Verification
The assertions assume that `vec_x` and `vec_y` stay within the 9-bit two's-complement range. Under that assumption, the registered sum never exceeds twice 256 squared, and the output never exceeds 362. The assertions also assume that `ce` is a clean level, sampled only at rising edges. To meet these assumptions, the bench drives its inputs on falling edges only, and it draws components uniformly from -256 to 255. In the random phase the bench drops `ce` on about a quarter of the cycles. It drives the asynchronous clear between edges, so that the clear can be seen acting without a clock edge.

// File: rtl/vmag_pkg.sv
package vmag_pkg;

  // Largest sum of squares for a signed component of in_w bits: 2 * (2^(in_w-1))^2
  function automatic longint unsigned sum_bound(input int in_w);
    longint unsigned half;
    half = longint'(1) << (in_w - 1);
    return 2 * half * half;
  endfunction

  // Upper bound on the floor root of sum_bound: 2^(in_w-1) * sqrt(2), rounded down
  function automatic longint unsigned mag_bound(input int in_w);
    longint unsigned half;
    half = longint'(1) << (in_w - 1);
    return (half * 17) / 12;
  endfunction

endpackage

// File: rtl/vmag_rst_sync.sv
module vmag_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_s_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_s_n = sync_q;

endmodule

// File: rtl/vmag_sumsq.sv
module vmag_sumsq #(
  parameter int IN_W  = 9,
  parameter int RAD_W = 18
) (
  input  logic                   clk,
  input  logic                   rst_s_n,
  input  logic                   ce,
  input  logic signed [IN_W-1:0] x_i,
  input  logic signed [IN_W-1:0] y_i,
  output logic [RAD_W-1:0]       sum_o
);

  localparam int SW = 2 * IN_W;
  localparam longint unsigned SUM_LIM = vmag_pkg::sum_bound(IN_W);

  logic signed [SW-1:0] xs, ys;
  logic [SW-1:0]        px, py;
  logic [RAD_W-1:0]     sum_d;
  logic [RAD_W-1:0]     sum_q;

  // next-state: exact squares, then their sum
  always_comb begin
    xs    = SW'(x_i);
    ys    = SW'(y_i);
    px    = xs * xs;
    py    = ys * ys;
    sum_d = RAD_W'(px + py);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      sum_q <= '0;
    end else if (ce) begin
      sum_q <= sum_d;
    end
  end

  assign sum_o = sum_q;

  // R2: the registered sum never exceeds the largest reachable sum of squares
  p_sum_range_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    64'(sum_q) <= SUM_LIM);

endmodule

// File: rtl/vmag_root_step.sv
module vmag_root_step #(
  parameter int OUT_W = 10
) (
  input  logic [OUT_W+1:0] rem_i,
  input  logic [OUT_W-1:0] root_i,
  input  logic [1:0]       pair_i,
  output logic [OUT_W+1:0] rem_o,
  output logic [OUT_W-1:0] root_o
);

  localparam int REM_W = OUT_W + 2;
  localparam int CW    = REM_W + 2;

  logic [CW-1:0] cand;
  logic [CW-1:0] trial;
  logic [CW-1:0] diff;
  logic          fits;

  // bring down the next bit pair and try to subtract 4*root + 1
  always_comb begin
    cand   = {rem_i, pair_i};
    trial  = CW'({root_i, 2'b01});
    fits   = (cand >= trial);
    diff   = cand - trial;
    rem_o  = fits ? diff[REM_W-1:0] : cand[REM_W-1:0];
    root_o = {root_i[OUT_W-2:0], fits};
  end

endmodule

// File: rtl/vmag_root.sv
module vmag_root #(
  parameter int OUT_W  = 10,
  parameter int RAD_W  = 18,
  parameter bit STAGED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_s_n,
  input  logic             ce,
  input  logic [RAD_W-1:0] rad_i,
  output logic [OUT_W-1:0] root_o
);

  localparam int REM_W = OUT_W + 2;
  localparam int PAD_W = 2 * OUT_W;
  localparam int PW    = 2 * OUT_W + 2;

  // index k holds what enters step k; index OUT_W is the finished result
  logic [REM_W-1:0] rem_s  [OUT_W+1];
  logic [OUT_W-1:0] root_s [OUT_W+1];
  logic [PAD_W-1:0] rad_s  [OUT_W];

  assign rem_s[0]  = '0;
  assign root_s[0] = '0;
  assign rad_s[0]  = PAD_W'(rad_i);

  for (genvar k = 0; k < OUT_W; k++) begin : g_step
    localparam int PB = 2 * (OUT_W - 1 - k);

    logic [REM_W-1:0] rem_d;
    logic [OUT_W-1:0] root_d;

    vmag_root_step #(.OUT_W(OUT_W)) u_step (
      .rem_i  (rem_s[k]),
      .root_i (root_s[k]),
      .pair_i (rad_s[k][PB+1:PB]),
      .rem_o  (rem_d),
      .root_o (root_d)
    );

    if (STAGED || (k == OUT_W - 1)) begin : g_reg
      always_ff @(posedge clk or negedge rst_s_n) begin
        if (!rst_s_n) begin
          rem_s[k+1]  <= '0;
          root_s[k+1] <= '0;
        end else if (ce) begin
          rem_s[k+1]  <= rem_d;
          root_s[k+1] <= root_d;
        end
      end

      if (k < OUT_W - 1) begin : g_rad
        always_ff @(posedge clk or negedge rst_s_n) begin
          if (!rst_s_n) begin
            rad_s[k+1] <= '0;
          end else if (ce) begin
            rad_s[k+1] <= rad_s[k];
          end
        end
      end

      // R3: a restoring root keeps the remainder at most twice the partial root
      p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
        REM_W'(rem_s[k+1]) <= (REM_W'(root_s[k+1]) << 1));
    end else begin : g_wire
      assign rem_s[k+1]  = rem_d;
      assign root_s[k+1] = root_d;
      assign rad_s[k+1]  = rad_s[k];
    end
  end

  if (!STAGED) begin : g_flat_chk
    // R3: the unregistered result of the flat form is the exact floor root of its input
    p_floor_exact_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
      (PW'(g_step[OUT_W-1].root_d) * PW'(g_step[OUT_W-1].root_d) <= PW'(rad_i)) &&
      ((PW'(g_step[OUT_W-1].root_d) + 1) * (PW'(g_step[OUT_W-1].root_d) + 1) > PW'(rad_i)));
  end

  assign root_o = root_s[OUT_W];

endmodule

// File: rtl/vec_mag.sv
module vec_mag #(
  parameter int IN_W   = 9,
  parameter int RAD_W  = 2 * IN_W,
  parameter int OUT_W  = 10,
  parameter bit STAGED = 1'b1
) (
  input  logic                   clk,
  input  logic                   arst_n,
  input  logic                   ce,
  input  logic signed [IN_W-1:0] vec_x,
  input  logic signed [IN_W-1:0] vec_y,
  output logic [OUT_W-1:0]       mag
);

  localparam longint unsigned MAG_LIM = vmag_pkg::mag_bound(IN_W);

  logic             rst_s_n;
  logic [RAD_W-1:0] sum;

  vmag_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_s_n (rst_s_n)
  );

  vmag_sumsq #(.IN_W(IN_W), .RAD_W(RAD_W)) u_sq (
    .clk     (clk),
    .rst_s_n (rst_s_n),
    .ce      (ce),
    .x_i     (vec_x),
    .y_i     (vec_y),
    .sum_o   (sum)
  );

  vmag_root #(.OUT_W(OUT_W), .RAD_W(RAD_W), .STAGED(STAGED)) u_root (
    .clk     (clk),
    .rst_s_n (rst_s_n),
    .ce      (ce),
    .rad_i   (sum),
    .root_o  (mag)
  );

  // R5: a disabled cycle leaves the output unchanged
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    !ce |=> $stable(mag));

  // R1: the result never exceeds the root of the largest sum of squares
  p_mag_max_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    64'(mag) <= MAG_LIM);

endmodule

// File: tb/sim_vec_mag.sv
`timescale 1ns/1ps
module sim_vec_mag;

  logic              clk;
  logic              arst_n;
  logic              ce;
  logic signed [8:0] vx, vy;
  logic [9:0]        mag0, mag1;

  int    total = 0;
  int    fails = 0;
  bit    done  = 0;
  int    n     = 0;
  int    hist [1024];
  string htag [1024];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  vec_mag #(.STAGED(1'b1)) u0 (
    .clk(clk), .arst_n(arst_n), .ce(ce), .vec_x(vx), .vec_y(vy), .mag(mag0));

  vec_mag #(.STAGED(1'b0)) u1 (
    .clk(clk), .arst_n(arst_n), .ce(ce), .vec_x(vx), .vec_y(vy), .mag(mag1));

  function automatic int isqrt(input int s);
    int r = 0;
    while ((r + 1) * (r + 1) <= s) r++;
    return r;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // one clock: drive on the falling edge, check 1 ns after the rising edge
  task automatic cyc(input int x, input int y, input bit e, input string tag);
    int p0, p1, e0, e1;
    @(negedge clk);
    vx = 9'(x);
    vy = 9'(y);
    ce = e;
    p0 = int'(mag0);
    p1 = int'(mag1);
    @(posedge clk);
    if (e) begin
      n++;
      hist[n % 1024] = isqrt(x * x + y * y);
      htag[n % 1024] = tag;
    end
    #1;
    if (e) begin
      e0 = (n > 10) ? hist[(n - 10) % 1024] : 0;
      e1 = (n > 1)  ? hist[(n - 1) % 1024]  : 0;
      check((n > 10) ? htag[(n - 10) % 1024] : "R4", int'(mag0), e0);
      check("R8", int'(mag1), e1);
    end else begin
      check("R5", int'(mag0), p0);
      check("R5", int'(mag1), p1);
    end
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < 12; i++) cyc(0, 0, 1'b1, tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0;
    ce     = 1'b0;
    vx     = '0;
    vy     = '0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R6", int'(mag0), 0);
    check("R6", int'(mag1), 0);
    @(negedge clk);
    arst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(0, 0, 1'b0, "R5");
    n = 0;

    // R4: fill latency, a single vector followed by zeros
    cyc(3, 4, 1'b1, "R4");
    flush("R4");

    // R3: perfect squares and values just below them
    cyc(5, 12, 1'b1, "R3");
    cyc(6, 8, 1'b1, "R3");
    cyc(1, 1, 1'b1, "R3");
    cyc(2, 1, 1'b1, "R3");
    cyc(15, -8, 1'b1, "R3");
    cyc(-20, -21, 1'b1, "R3");
    cyc(3, 3, 1'b1, "R3");
    // R2: largest sums of squares
    cyc(-256, -256, 1'b1, "R2");
    cyc(255, -256, 1'b1, "R2");
    cyc(-256, 255, 1'b1, "R2");
    cyc(255, 255, 1'b1, "R2");
    // R7: zero and single-axis vectors
    cyc(0, 0, 1'b1, "R7");
    cyc(-256, 0, 1'b1, "R7");
    cyc(0, -256, 1'b1, "R7");
    cyc(0, -1, 1'b1, "R7");
    cyc(255, 0, 1'b1, "R7");
    flush("R1");

    // R1 random stream, R5 stalls mixed in
    for (int i = 0; i < 1500; i++) begin
      int x, y;
      bit e;
      x = int'($urandom % 512) - 256;
      y = int'($urandom % 512) - 256;
      e = ($urandom % 4) != 0;
      cyc(x, y, e, "R1");
    end
    // R5: a long stall in the middle of a full pipeline
    for (int i = 0; i < 6; i++) cyc(100 + i, -50, 1'b1, "R5");
    for (int i = 0; i < 8; i++) cyc(-7, 9, 1'b0, "R5");
    flush("R5");

    // R6: asynchronous clear with a nonzero pipeline
    for (int i = 0; i < 12; i++) cyc(255, 255, 1'b1, "R6");
    @(posedge clk);
    #2;
    arst_n = 1'b0;
    #1;
    check("R6", int'(mag0), 0);
    check("R6", int'(mag1), 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    arst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(0, 0, 1'b0, "R6");
    n = 0;
    cyc(-9, 40, 1'b1, "R6");
    cyc(30, 40, 1'b1, "R6");
    flush("R6");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule